// File: doc/BRIEF.md
# Sparse Operand Pair Mapper

This controller prepares the routing work for a sparse matrix product in which one operand stays resident in a row of fixed-size multiply engines and the other operand is streamed past it. Both operands arrive only as occupancy bitmaps. The stationary bitmap has ROWS rows and COLS columns. The streaming bitmap has COLS rows and SCOLS columns. The bitmaps are written one row per cycle into internal storage. A start pulse then launches one mapping job.

A job runs in fixed steps. The block first finds every streaming row that holds at least one set bit. It clears each stationary bit whose partner streaming row is entirely empty, then counts the surviving bits and works out how many engines of LANES multipliers they fill. The surviving stationary bits are numbered in row-major order with a counter that wraps at the engine width. Set streaming bits are numbered within their own column. The block then walks every streaming column against every stationary row and emits one routing entry per matching pair over a valid/ready stream. Each entry carries the engine, the streaming-side index, the lane and the row, where the row acts as the partial-sum group. A bitmap of the output positions that receive at least one product is produced alongside.

Top module: `sparse_pair_mapper`

## Requirements
- R1: After a synchronous reset, busy, done and tbl_valid are 0, and pruned_bitmap, nz_count, engine_count and out_bitmap are all zero.
- R2: A start pulse while idle raises busy from the next cycle. busy stays high until the job ends. Start pulses and bitmap writes that arrive while busy is high are dropped.
- R3: pruned_bitmap bit r*COLS+k equals stationary bit (r,k) AND the OR of all bits in streaming row k.
- R4: nz_count is the number of ones in pruned_bitmap. engine_count is nz_count divided by LANES, rounded up.
- R5: Surviving stationary bits are ranked from 0 in row-major order (row ascending, then column ascending). Each entry's tbl_dst is that rank modulo LANES, and its tbl_engine is the rank divided by LANES.
- R6: The tbl_src of an entry is the number of set streaming bits above row k in the same streaming column n.
- R7: One entry is produced for each triple (n,r,k) with streaming bit (k,n) and pruned bit (r,k) both set. Entries come in order of ascending n, then r, then k, and tbl_row carries r.
- R8: While tbl_valid is high and tbl_ready is low, the entry is held unchanged. An entry is consumed on a cycle where both are high.
- R9: done is a one-cycle pulse in the cycle after the last entry is consumed, or after the scan when there are no entries. busy is low in that cycle, and tbl_valid is low.
- R10: out_bitmap bit r*SCOLS+n is 1 exactly when some k has pruned bit (r,k) and streaming bit (k,n) both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_we | input | 1 | Write one stationary bitmap row |
| st_addr | input | ROWW | Stationary row number |
| st_data | input | COLS | Stationary row bits, bit k is column k |
| sm_we | input | 1 | Write one streaming bitmap row |
| sm_addr | input | KW | Streaming row number |
| sm_data | input | SCOLS | Streaming row bits, bit n is column n |
| start | input | 1 | Launch a mapping job |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| pruned_bitmap | output | ROWS*COLS | Stationary bitmap after pruning |
| nz_count | output | NZW | Number of surviving stationary bits |
| engine_count | output | ENGW | Engines required |
| out_bitmap | output | ROWS*SCOLS | Output positions that receive a product |
| tbl_valid | output | 1 | Routing entry present |
| tbl_ready | input | 1 | Consumer accepts the entry |
| tbl_engine | output | ENGW | Engine of the entry |
| tbl_src | output | KW | Streaming-side index within the column |
| tbl_dst | output | LANEW | Lane inside the engine |
| tbl_row | output | ROWW | Row, used as the partial-sum group |

## Verification
A stale or wrongly pruned stationary copy shows up in pruned_bitmap, nz_count and engine_count once the job's first stage completes. It also shows up in the walk as missing or extra entries. A rank counter that wraps at the wrong point shows up as a wrong lane or engine on the first entry past an engine boundary. A cursor fault shows up as entries out of column-major order, or as a done pulse that comes too early or never. The scoreboard compares every entry in order as it is handed over, so any of these faults appears within the job that causes it.

// File: rtl/sparse_map_pkg.sv
package sparse_map_pkg;
  // index width that never drops below one bit
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // width able to hold the value n itself
  function automatic int cnt_w(input int n);
    return $clog2(n + 1);
  endfunction

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
endpackage

// File: rtl/bitmap_store.sv
module bitmap_store #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 4,
  localparam int AW = sparse_map_pkg::idx_w(DEPTH)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [AW-1:0]                addr,
  input  logic [WIDTH-1:0]             wdata,
  output logic [DEPTH-1:0][WIDTH-1:0]  bits
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bits <= '0;
    end else if (we && (int'(addr) < DEPTH)) begin
      bits[addr] <= wdata;
    end
  end
endmodule

// File: rtl/prune_unit.sv
module prune_unit #(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int SCOLS = 4,
  parameter int LANES = 4,
  localparam int RC   = ROWS * COLS,
  localparam int NZW  = sparse_map_pkg::cnt_w(RC),
  localparam int ENGW = sparse_map_pkg::cnt_w(sparse_map_pkg::ceil_div(RC, LANES))
) (
  input  logic [ROWS-1:0][COLS-1:0]   st,
  input  logic [COLS-1:0][SCOLS-1:0]  sm,
  output logic [ROWS-1:0][COLS-1:0]   pruned,
  output logic [NZW-1:0]              nz,
  output logic [ENGW-1:0]             eng,
  output logic [ROWS-1:0][SCOLS-1:0]  outmap
);
  logic [COLS-1:0] row_any;

  // one OR reduction per streaming row
  for (genvar k = 0; k < COLS; k++) begin : g_any
    assign row_any[k] = |sm[k];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_prune
    assign pruned[r] = st[r] & row_any;
  end

  always_comb begin
    int acc;
    acc = 0;
    for (int r = 0; r < ROWS; r++) begin
      for (int k = 0; k < COLS; k++) begin
        acc += int'(pruned[r][k]);
      end
    end
    nz  = NZW'(acc);
    eng = ENGW'(sparse_map_pkg::ceil_div(acc, LANES));
  end

  always_comb begin
    outmap = '0;
    for (int r = 0; r < ROWS; r++) begin
      for (int n = 0; n < SCOLS; n++) begin
        for (int k = 0; k < COLS; k++) begin
          outmap[r][n] = outmap[r][n] | (pruned[r][k] & sm[k][n]);
        end
      end
    end
  end
endmodule

// File: rtl/rank_unit.sv
module rank_unit #(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int SCOLS = 4,
  parameter int LANES = 4,
  localparam int RC    = ROWS * COLS,
  localparam int LANEW = sparse_map_pkg::idx_w(LANES),
  localparam int ENGW  = sparse_map_pkg::cnt_w(sparse_map_pkg::ceil_div(RC, LANES)),
  localparam int KW    = sparse_map_pkg::idx_w(COLS)
) (
  input  logic [ROWS-1:0][COLS-1:0]             pruned,
  input  logic [COLS-1:0][SCOLS-1:0]            sm,
  output logic [RC-1:0][LANEW-1:0]              lane,
  output logic [RC-1:0][ENGW-1:0]               engid,
  output logic [COLS-1:0][SCOLS-1:0][KW-1:0]    smrank
);
  // stationary ranks: row-major, lane wraps at the engine width
  always_comb begin
    int acc;
    acc = 0;
    for (int r = 0; r < ROWS; r++) begin
      for (int k = 0; k < COLS; k++) begin
        lane[r*COLS+k]  = LANEW'(acc % LANES);
        engid[r*COLS+k] = ENGW'(acc / LANES);
        acc += int'(pruned[r][k]);
      end
    end
  end

  // streaming ranks: restart at the top of each column
  for (genvar n = 0; n < SCOLS; n++) begin : g_col
    always_comb begin
      int cnt;
      cnt = 0;
      for (int k = 0; k < COLS; k++) begin
        smrank[k][n] = KW'(cnt);
        cnt += int'(sm[k][n]);
      end
    end
  end
endmodule

// File: rtl/pair_walker.sv
module pair_walker #(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int SCOLS = 4,
  parameter int LANES = 4,
  localparam int RC    = ROWS * COLS,
  localparam int LANEW = sparse_map_pkg::idx_w(LANES),
  localparam int ENGW  = sparse_map_pkg::cnt_w(sparse_map_pkg::ceil_div(RC, LANES)),
  localparam int KW    = sparse_map_pkg::idx_w(COLS),
  localparam int ROWW  = sparse_map_pkg::idx_w(ROWS),
  localparam int SCW   = sparse_map_pkg::idx_w(SCOLS)
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               launch,
  input  logic [ROWS-1:0][COLS-1:0]          pruned,
  input  logic [COLS-1:0][SCOLS-1:0]         sm,
  input  logic [RC-1:0][LANEW-1:0]           lane,
  input  logic [RC-1:0][ENGW-1:0]            engid,
  input  logic [COLS-1:0][SCOLS-1:0][KW-1:0] smrank,
  input  logic [ROWS-1:0][SCOLS-1:0]         outmap,
  input  logic                               ready,
  output logic                               valid,
  output logic [ENGW-1:0]                    o_eng,
  output logic [KW-1:0]                      o_src,
  output logic [LANEW-1:0]                   o_dst,
  output logic [ROWW-1:0]                    o_row,
  output logic                               active,
  output logic                               done
);
  logic [SCW-1:0]  n_q;
  logic [ROWW-1:0] r_q;
  logic [KW-1:0]   k_q;
  logic [SCW-1:0]  ocol_q;
  logic            scan_q;
  logic            hit;
  logic            last;
  int              idx;

  assign idx  = int'(r_q) * COLS + int'(k_q);
  assign hit  = sm[k_q][n_q] & pruned[r_q][k_q];
  assign last = (n_q == SCW'(SCOLS-1)) && (r_q == ROWW'(ROWS-1)) && (k_q == KW'(COLS-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      scan_q <= 1'b0;
      done   <= 1'b0;
      valid  <= 1'b0;
      n_q    <= '0;
      r_q    <= '0;
      k_q    <= '0;
      ocol_q <= '0;
      o_eng  <= '0;
      o_src  <= '0;
      o_dst  <= '0;
      o_row  <= '0;
    end else begin
      done <= 1'b0;
      if (launch) begin
        active <= 1'b1;
        scan_q <= 1'b1;
        valid  <= 1'b0;
        n_q    <= '0;
        r_q    <= '0;
        k_q    <= '0;
      end else if (active && (!valid || ready)) begin
        if (scan_q) begin
          valid  <= hit;
          o_eng  <= engid[idx];
          o_src  <= smrank[k_q][n_q];
          o_dst  <= lane[idx];
          o_row  <= r_q;
          ocol_q <= n_q;
          if (last) scan_q <= 1'b0;
          // innermost k, then row, then streaming column
          if (k_q == KW'(COLS-1)) begin
            k_q <= '0;
            if (r_q == ROWW'(ROWS-1)) begin
              r_q <= '0;
              n_q <= n_q + 1'b1;
            end else begin
              r_q <= r_q + 1'b1;
            end
          end else begin
            k_q <= k_q + 1'b1;
          end
        end else begin
          valid  <= 1'b0;
          active <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  // R8: a stalled entry is held
  a_r8_hold_entry: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable({o_eng, o_src, o_dst, o_row})));

  // R10: every emitted pair lands on a marked output position
  a_r10_entry_marked: assert property (@(posedge clk) disable iff (rst)
    valid |-> outmap[o_row][ocol_q]);

  // R9: nothing pending when the job ends
  a_r9_done_clean: assert property (@(posedge clk) disable iff (rst)
    done |-> !valid);
endmodule

// File: rtl/sparse_pair_mapper.sv
module sparse_pair_mapper #(
  parameter int ROWS  = 4,
  parameter int COLS  = 4,
  parameter int SCOLS = 4,
  parameter int LANES = 4,
  localparam int RC    = ROWS * COLS,
  localparam int NZW   = sparse_map_pkg::cnt_w(RC),
  localparam int ENGW  = sparse_map_pkg::cnt_w(sparse_map_pkg::ceil_div(RC, LANES)),
  localparam int LANEW = sparse_map_pkg::idx_w(LANES),
  localparam int KW    = sparse_map_pkg::idx_w(COLS),
  localparam int ROWW  = sparse_map_pkg::idx_w(ROWS)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  st_we,
  input  logic [ROWW-1:0]       st_addr,
  input  logic [COLS-1:0]       st_data,
  input  logic                  sm_we,
  input  logic [KW-1:0]         sm_addr,
  input  logic [SCOLS-1:0]      sm_data,
  input  logic                  start,
  output logic                  busy,
  output logic                  done,
  output logic [RC-1:0]         pruned_bitmap,
  output logic [NZW-1:0]        nz_count,
  output logic [ENGW-1:0]       engine_count,
  output logic [ROWS*SCOLS-1:0] out_bitmap,
  output logic                  tbl_valid,
  input  logic                  tbl_ready,
  output logic [ENGW-1:0]       tbl_engine,
  output logic [KW-1:0]         tbl_src,
  output logic [LANEW-1:0]      tbl_dst,
  output logic [ROWW-1:0]       tbl_row
);
  logic [ROWS-1:0][COLS-1:0]           st_bits;
  logic [COLS-1:0][SCOLS-1:0]          sm_bits;
  logic [ROWS-1:0][COLS-1:0]           pruned_c;
  logic [ROWS-1:0][COLS-1:0]           pruned_q;
  logic [NZW-1:0]                      nz_c;
  logic [ENGW-1:0]                     eng_c;
  logic [ROWS-1:0][SCOLS-1:0]          outmap_c;
  logic [ROWS-1:0][SCOLS-1:0]          outmap_q;
  logic [RC-1:0][LANEW-1:0]            lane_c;
  logic [RC-1:0][ENGW-1:0]             engid_c;
  logic [COLS-1:0][SCOLS-1:0][KW-1:0]  smrank_c;
  logic                                prep_q;
  logic                                walk_active;

  assign busy = prep_q | walk_active;

  bitmap_store #(.DEPTH(ROWS), .WIDTH(COLS)) u_st_store (
    .clk(clk), .rst(rst), .we(st_we && !busy), .addr(st_addr),
    .wdata(st_data), .bits(st_bits));

  bitmap_store #(.DEPTH(COLS), .WIDTH(SCOLS)) u_sm_store (
    .clk(clk), .rst(rst), .we(sm_we && !busy), .addr(sm_addr),
    .wdata(sm_data), .bits(sm_bits));

  prune_unit #(.ROWS(ROWS), .COLS(COLS), .SCOLS(SCOLS), .LANES(LANES)) u_prune (
    .st(st_bits), .sm(sm_bits), .pruned(pruned_c), .nz(nz_c),
    .eng(eng_c), .outmap(outmap_c));

  rank_unit #(.ROWS(ROWS), .COLS(COLS), .SCOLS(SCOLS), .LANES(LANES)) u_rank (
    .pruned(pruned_q), .sm(sm_bits), .lane(lane_c), .engid(engid_c),
    .smrank(smrank_c));

  always_ff @(posedge clk) begin
    if (rst) begin
      prep_q       <= 1'b0;
      pruned_q     <= '0;
      nz_count     <= '0;
      engine_count <= '0;
      outmap_q     <= '0;
    end else begin
      prep_q <= start && !busy;
      if (prep_q) begin
        pruned_q     <= pruned_c;
        nz_count     <= nz_c;
        engine_count <= eng_c;
        outmap_q     <= outmap_c;
      end
    end
  end

  assign pruned_bitmap = pruned_q;
  assign out_bitmap    = outmap_q;

  pair_walker #(.ROWS(ROWS), .COLS(COLS), .SCOLS(SCOLS), .LANES(LANES)) u_walk (
    .clk(clk), .rst(rst), .launch(prep_q), .pruned(pruned_q), .sm(sm_bits),
    .lane(lane_c), .engid(engid_c), .smrank(smrank_c), .outmap(outmap_q),
    .ready(tbl_ready), .valid(tbl_valid), .o_eng(tbl_engine), .o_src(tbl_src),
    .o_dst(tbl_dst), .o_row(tbl_row), .active(walk_active), .done(done));

  // R2: an idle start raises busy next cycle
  a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R9: job end coincides with busy low
  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R3: during the walk the pruned copy never exceeds the frozen stationary bitmap
  a_r3_pruned_subset: assert property (@(posedge clk) disable iff (rst)
    walk_active |-> ((pruned_q & ~st_bits) == '0));

  // R4: engine count covers the survivors with less than one spare engine
  a_r4_engine_cover: assert property (@(posedge clk) disable iff (rst)
    !busy |-> ((int'(engine_count) * LANES >= int'(nz_count)) &&
               (int'(nz_count) > (int'(engine_count) - 1) * LANES)));
endmodule

// File: tb/sparse_pair_mapper_tb.sv
module sparse_pair_mapper_tb_top;
  localparam int R = 4;
  localparam int C = 4;
  localparam int S = 4;
  localparam int L = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic st_we = 1'b0;
  logic [1:0] st_addr = '0;
  logic [C-1:0] st_data = '0;
  logic sm_we = 1'b0;
  logic [1:0] sm_addr = '0;
  logic [S-1:0] sm_data = '0;
  logic start = 1'b0;
  logic busy, done, tbl_valid;
  logic tbl_ready = 1'b0;
  logic [R*C-1:0] pruned_bitmap;
  logic [4:0] nz_count;
  logic [2:0] engine_count, tbl_engine;
  logic [R*S-1:0] out_bitmap;
  logic [1:0] tbl_src, tbl_dst, tbl_row;

  int errors = 0;
  int checks = 0;
  int ready_mode = 0;
  logic [7:0] lfsr = 8'hA5;
  int exp_q[$];
  int st_m[R][C];
  int sm_m[C][S];

  always #4 clk = ~clk;

  sparse_pair_mapper dut_i (
    .clk(clk), .rst(rst), .st_we(st_we), .st_addr(st_addr), .st_data(st_data),
    .sm_we(sm_we), .sm_addr(sm_addr), .sm_data(sm_data), .start(start),
    .busy(busy), .done(done), .pruned_bitmap(pruned_bitmap), .nz_count(nz_count),
    .engine_count(engine_count), .out_bitmap(out_bitmap), .tbl_valid(tbl_valid),
    .tbl_ready(tbl_ready), .tbl_engine(tbl_engine), .tbl_src(tbl_src),
    .tbl_dst(tbl_dst), .tbl_row(tbl_row));

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h expected=%0h", req, got, exp);
    end
  endtask

  function automatic int key(input int e, input int s, input int d, input int r);
    return e * 16777216 + s * 65536 + d * 256 + r;
  endfunction

  // monitor: choose ready, then pop on a handshake seen with that ready
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    tbl_ready = (ready_mode == 0) ? 1'b1 : lfsr[0];
    if (!rst && tbl_valid && tbl_ready) begin
      if (exp_q.size() == 0) begin
        check("R7 unexpected entry", key(int'(tbl_engine), int'(tbl_src), int'(tbl_dst), int'(tbl_row)), -1);
      end else begin
        check("R5 R6 R7 entry", key(int'(tbl_engine), int'(tbl_src), int'(tbl_dst), int'(tbl_row)),
              exp_q.pop_front());
      end
    end
  end

  task automatic load_all();
    for (int r = 0; r < R; r++) begin
      @(negedge clk);
      st_we = 1'b1; st_addr = 2'(r);
      for (int k = 0; k < C; k++) st_data[k] = st_m[r][k][0];
    end
    for (int k = 0; k < C; k++) begin
      @(negedge clk);
      st_we = 1'b0; sm_we = 1'b1; sm_addr = 2'(k);
      for (int n = 0; n < S; n++) sm_data[n] = sm_m[k][n][0];
    end
    @(negedge clk);
    st_we = 1'b0; sm_we = 1'b0;
  endtask

  task automatic run_job(input string tag, input int rmode, input bit poke);
    int pr[R][C];
    int any_k, rank, cnt, nz, eng, cycles, pulses;
    logic [R*C-1:0] exp_pr;
    logic [R*S-1:0] exp_out;
    int lane_of[R][C];
    int srank[C][S];
    exp_pr = '0; exp_out = '0; nz = 0; rank = 0;
    for (int r = 0; r < R; r++)
      for (int k = 0; k < C; k++) begin
        any_k = 0;
        for (int n = 0; n < S; n++) any_k |= sm_m[k][n];
        pr[r][k] = st_m[r][k] & any_k;
        exp_pr[r*C+k] = pr[r][k][0];
        lane_of[r][k] = rank;
        rank += pr[r][k];
      end
    nz = rank;
    eng = (nz + L - 1) / L;
    for (int n = 0; n < S; n++) begin
      cnt = 0;
      for (int k = 0; k < C; k++) begin
        srank[k][n] = cnt;
        cnt += sm_m[k][n];
      end
    end
    for (int n = 0; n < S; n++)
      for (int r = 0; r < R; r++)
        for (int k = 0; k < C; k++)
          if (sm_m[k][n] == 1 && pr[r][k] == 1) begin
            exp_q.push_back(key(lane_of[r][k] / L, srank[k][n], lane_of[r][k] % L, r));
            exp_out[r*S+n] = 1'b1;
          end
    ready_mode = rmode;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({"R2 busy after start ", tag}, int'(busy), 1);
    if (poke) begin
      // writes and a second start while busy must be dropped
      st_we = 1'b1; st_addr = 2'd0; st_data = '1;
      sm_we = 1'b1; sm_addr = 2'd0; sm_data = '1;
      start = 1'b1;
      @(negedge clk);
      st_we = 1'b0; sm_we = 1'b0; start = 1'b0;
    end
    cycles = 0;
    while (!done && cycles < 2000) begin
      @(negedge clk);
      cycles++;
    end
    check({"R9 done seen ", tag}, int'(done), 1);
    check({"R9 busy low at done ", tag}, int'(busy), 0);
    check({"R7 all entries out ", tag}, exp_q.size(), 0);
    exp_q.delete();
    check({"R3 pruned ", tag}, int'(pruned_bitmap), int'(exp_pr));
    check({"R4 nz ", tag}, int'(nz_count), nz);
    check({"R4 engines ", tag}, int'(engine_count), eng);
    check({"R10 out bitmap ", tag}, int'(out_bitmap), int'(exp_out));
    pulses = 0;
    @(negedge clk);
    pulses += int'(done);
    check({"R9 single pulse ", tag}, pulses, 0);
    check({"R2 idle after job ", tag}, int'(busy), 0);
  endtask

  task automatic pattern(input int seed);
    int v;
    v = seed;
    for (int r = 0; r < R; r++)
      for (int k = 0; k < C; k++) begin
        v = (v * 1103515245 + 12345) & 32'h7fffffff;
        st_m[r][k] = (v >> 16) & 1;
      end
    for (int k = 0; k < C; k++)
      for (int n = 0; n < S; n++) begin
        v = (v * 1103515245 + 12345) & 32'h7fffffff;
        sm_m[k][n] = ((v >> 16) % 3 == 0) ? 1 : 0;
      end
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 valid", int'(tbl_valid), 0);
    check("R1 pruned", int'(pruned_bitmap), 0);
    check("R1 counts", int'(nz_count) + int'(engine_count), 0);
    check("R1 out", int'(out_bitmap), 0);

    // streaming row 2 empty: column 2 of the stationary matrix is pruned
    for (int r = 0; r < R; r++) for (int k = 0; k < C; k++) st_m[r][k] = ((r + k) % 2 == 0 || k == 2) ? 1 : 0;
    for (int k = 0; k < C; k++) for (int n = 0; n < S; n++) sm_m[k][n] = (k != 2 && (k + n) % 3 != 1) ? 1 : 0;
    load_all();
    run_job("prune", 0, 1'b0);

    // dense: 16 survivors, 4 engines, every lane wrap exercised
    for (int r = 0; r < R; r++) for (int k = 0; k < C; k++) st_m[r][k] = 1;
    for (int k = 0; k < C; k++) for (int n = 0; n < S; n++) sm_m[k][n] = 1;
    load_all();
    run_job("dense", 1, 1'b0);

    // held results: writes during the job dropped, rerun must match
    run_job("poke", 1, 1'b1);
    run_job("after poke", 0, 1'b0);

    // empty streaming matrix: no entries, zero counts
    for (int k = 0; k < C; k++) for (int n = 0; n < S; n++) sm_m[k][n] = 0;
    load_all();
    run_job("empty", 0, 1'b0);

    // five survivors: engines round up to 2
    for (int r = 0; r < R; r++) for (int k = 0; k < C; k++) st_m[r][k] = (r * C + k < 5) ? 1 : 0;
    for (int k = 0; k < C; k++) for (int n = 0; n < S; n++) sm_m[k][n] = (n == k) ? 1 : 0;
    load_all();
    run_job("five", 1, 1'b0);

    for (int t = 0; t < 6; t++) begin
      pattern(t * 77 + 3);
      load_all();
      run_job($sformatf("mixed%0d", t), t % 2, 1'b0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule